// File: doc/BRIEF.md
# Simple Dual-Port Block RAM

This block is a 4096-bit on-chip memory with one write port and one read port, both clocked by a single clock. The depth-by-width shape is fixed at elaboration by the `WIDTH` parameter. Depth follows as 4096 divided by `WIDTH`. Both addresses pass through input registers, and each of those registers has its own hold input, so either port can keep using its last address while its address bus carries something else.

A global clock enable freezes the whole block. For the 16-bit and 8-bit shapes, writes can be masked one byte at a time. Reads can be gated by a read enable. When `HAS_RDEN` is 0 there is no read gating, and the output keeps tracking the contents at the registered read address. An optional output register adds one cycle of read latency.

Both ports are plain memory ports and carry no valid/ready handshake. A write lands at the clock edge that captures it. A read result appears after the edge that captures the read request, or one edge later when the output register is present. This block cannot stall, so there is no back-pressure.

Top module: `sdp_ram`

## Requirements
- R1: `WIDTH` must be 16, 8, 4, 2 or 1. The depth is 4096/`WIDTH` and the address width is log2 of the depth.
- R2: A word is written only at a rising edge where both `clk_en` and `wr_en` are high. If `wr_en` is low at that edge, no location changes.
- R3: For widths 16 and 8, `byte_en[i]` controls data bits [8i+7:8i]. A lane whose enable is 0 keeps its old contents.
- R4: For widths below 8, `byte_en` is ignored and every enabled write updates the whole word.
- R5: When `rd_addr_hold` is high, the read address register keeps its previous value, and reads use that held address.
- R6: When `wr_addr_hold` is high, the write address register keeps its previous value, and writes go to the held address.
- R7: With `HAS_RDEN`=1, an edge where `rd_en` is low leaves `rd_data` unchanged.
- R8: With `HAS_RDEN`=0, every enabled edge reads the registered read address, so a write to that address shows up without a new read request.
- R9: If a read and a write hit the same address at the same edge, the read returns the data held before the write.
- R10: Read latency is one clock edge when `OUT_REG`=0 and two edges when `OUT_REG`=1.
- R11: While `clk_en` is low, no register and no memory location changes, and `rd_data` stays stable.
- R12: Reset (`rst_n` low) clears `rd_data` and both address registers to zero. Memory contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Global clock enable |
| wr_en | input | 1 | Write request |
| wr_addr | input | AW | Write address |
| wr_addr_hold | input | 1 | Keep the previous write address |
| wr_data | input | WIDTH | Write data |
| byte_en | input | BE_W | Per-byte write mask; BE_W is WIDTH/8, or 1 for narrow shapes |
| rd_en | input | 1 | Read request; ignored when HAS_RDEN=0 |
| rd_addr | input | AW | Read address |
| rd_addr_hold | input | 1 | Keep the previous read address |
| rd_data | output | WIDTH | Read data |

## Verification
The bench targets the following corner cases, each of which a broken design would visibly get wrong:

- **Read/write collision.** A read and a write to the same address at the same edge must return the old data. A design with write-first forwarding would return the new word one cycle early.
- **Address holds.** With a hold asserted, a new address must not be loaded. A design that loads it would read or write the wrong location: a read would return a neighbour's word, and a write would corrupt it.
- **Byte masking.** Clearing one lane enable must leave that lane untouched. A design that ignores the mask would overwrite it. For narrow shapes the mask must not matter, so a design that obeys it would drop whole writes.
- **Latency and gating.** A pipeline one stage too short or too long shifts the whole address sweep by one entry. A clock enable that fails to freeze the block would let a write slip through.

// File: rtl/sdp_ram_pkg.sv
package sdp_ram_pkg;

  localparam int unsigned CAPACITY_BITS = 4096;

  function automatic int unsigned lane_count(int unsigned w);
    return (w >= 8) ? (w / 8) : 1;
  endfunction

  function automatic int unsigned lane_width(int unsigned w);
    return (w >= 8) ? 8 : w;
  endfunction

  function automatic bit shape_ok(int unsigned w);
    return (w == 16) || (w == 8) || (w == 4) || (w == 2) || (w == 1);
  endfunction

endpackage

// File: rtl/sdp_addr_reg.sv
module sdp_addr_reg #(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic          hold,
  input  logic [AW-1:0] d,
  output logic [AW-1:0] eff
);

  logic [AW-1:0] q;

  // Address seen by the array at this edge: the held copy or the new bus value
  assign eff = hold ? q : d;

  always_ff @(posedge clk) begin
    if (!rst_n)
      q <= '0;
    else if (ce && !hold)
      q <= d;
  end

  // R5, R6
  addr_hold_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && hold) |=> $stable(q));

  // R11
  addr_ce_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(q));

endmodule

// File: rtl/sdp_mem_array.sv
module sdp_mem_array
  import sdp_ram_pkg::*;
#(
  parameter int unsigned WIDTH    = 16,
  parameter int unsigned DEPTH    = 256,
  parameter int unsigned AW       = 8,
  parameter int unsigned BE_W     = 2,
  parameter bit          HAS_RDEN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [BE_W-1:0]  be,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rd_q
);

  localparam int unsigned NL = lane_count(WIDTH);
  localparam int unsigned LW = lane_width(WIDTH);

  logic read_fire;
  assign read_fire = ce && (re || !HAS_RDEN);

  logic [LW-1:0] lane_q [NL];

  for (genvar l = 0; l < NL; l++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];
    logic          lane_mask;
    logic          lane_we;

    assign lane_mask = (WIDTH >= 8) ? be[l] : 1'b1;
    assign lane_we   = ce && we && lane_mask;

    always_ff @(posedge clk) begin
      if (lane_we)
        mem[waddr] <= wdata[l*LW +: LW];
    end

    // Nonblocking read sees pre-write contents: read-before-write
    always_ff @(posedge clk) begin
      if (!rst_n)
        lane_q[l] <= '0;
      else if (read_fire)
        lane_q[l] <= mem[raddr];
    end
  end

  always_comb begin
    for (int l = 0; l < NL; l++)
      rd_q[l*LW +: LW] = lane_q[l];
  end

  // R7
  rden_low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_RDEN && !re) |=> $stable(rd_q));

  // R11
  array_ce_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(rd_q));

endmodule

// File: rtl/sdp_out_stage.sv
module sdp_out_stage #(
  parameter int unsigned WIDTH   = 16,
  parameter bit          OUT_REG = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  if (OUT_REG) begin : g_reg
    logic [WIDTH-1:0] r;

    always_ff @(posedge clk) begin
      if (!rst_n)
        r <= '0;
      else if (ce)
        r <= din;
    end

    assign dout = r;

    // R11
    out_ce_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ce |=> $stable(dout));
  end else begin : g_pass
    assign dout = din;
  end

endmodule

// File: rtl/sdp_ram.sv
module sdp_ram
  import sdp_ram_pkg::*;
#(
  parameter int unsigned WIDTH    = 16,
  parameter bit          OUT_REG  = 1'b0,
  parameter bit          HAS_RDEN = 1'b1,
  localparam int unsigned DEPTH   = CAPACITY_BITS / WIDTH,
  localparam int unsigned AW      = $clog2(DEPTH),
  localparam int unsigned BE_W    = lane_count(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic             wr_addr_hold,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [BE_W-1:0]  byte_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  input  logic             rd_addr_hold,
  output logic [WIDTH-1:0] rd_data
);

  // R1
  initial shape_chk: assert (shape_ok(WIDTH));

  logic [AW-1:0]    waddr_eff;
  logic [AW-1:0]    raddr_eff;
  logic [WIDTH-1:0] array_q;

  sdp_addr_reg #(.AW(AW)) u_waddr (
    .clk  (clk),
    .rst_n(rst_n),
    .ce   (clk_en),
    .hold (wr_addr_hold),
    .d    (wr_addr),
    .eff  (waddr_eff)
  );

  sdp_addr_reg #(.AW(AW)) u_raddr (
    .clk  (clk),
    .rst_n(rst_n),
    .ce   (clk_en),
    .hold (rd_addr_hold),
    .d    (rd_addr),
    .eff  (raddr_eff)
  );

  sdp_mem_array #(
    .WIDTH   (WIDTH),
    .DEPTH   (DEPTH),
    .AW      (AW),
    .BE_W    (BE_W),
    .HAS_RDEN(HAS_RDEN)
  ) u_array (
    .clk  (clk),
    .rst_n(rst_n),
    .ce   (clk_en),
    .we   (wr_en),
    .waddr(waddr_eff),
    .wdata(wr_data),
    .be   (byte_en),
    .re   (rd_en),
    .raddr(raddr_eff),
    .rd_q (array_q)
  );

  sdp_out_stage #(
    .WIDTH  (WIDTH),
    .OUT_REG(OUT_REG)
  ) u_out (
    .clk  (clk),
    .rst_n(rst_n),
    .ce   (clk_en),
    .din  (array_q),
    .dout (rd_data)
  );

endmodule

// File: tb/tb_sdp_ram.sv
module tb_sdp_ram;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic rst_n, ce;

  // Configuration A: 256 x 16, no output register, with read enable
  logic        a_we, a_wh, a_re, a_rh;
  logic [7:0]  a_wa, a_ra;
  logic [15:0] a_wd, a_rd;
  logic [1:0]  a_be;

  // Configuration B: 1024 x 4, output register, continuous read
  logic        b_we, b_wh, b_re, b_rh;
  logic [9:0]  b_wa, b_ra;
  logic [3:0]  b_wd, b_rd;
  logic [0:0]  b_be;

  sdp_ram #(.WIDTH(16), .OUT_REG(1'b0), .HAS_RDEN(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .clk_en(ce),
    .wr_en(a_we), .wr_addr(a_wa), .wr_addr_hold(a_wh), .wr_data(a_wd),
    .byte_en(a_be), .rd_en(a_re), .rd_addr(a_ra), .rd_addr_hold(a_rh),
    .rd_data(a_rd)
  );

  sdp_ram #(.WIDTH(4), .OUT_REG(1'b1), .HAS_RDEN(1'b0)) dut_b (
    .clk(clk), .rst_n(rst_n), .clk_en(ce),
    .wr_en(b_we), .wr_addr(b_wa), .wr_addr_hold(b_wh), .wr_data(b_wd),
    .byte_en(b_be), .rd_en(b_re), .rd_addr(b_ra), .rd_addr_hold(b_rh),
    .rd_data(b_rd)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [15:0] ma [256];
  logic [3:0]  mb [1024];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic a_read(input int addr, input string req);
    a_re = 1'b1; a_ra = addr[7:0];
    @(negedge clk);
    check(a_rd == ma[addr], req, a_rd, ma[addr]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ce = 1'b1;
    a_we = 0; a_wh = 0; a_re = 0; a_rh = 0; a_wa = 0; a_ra = 0; a_wd = 0; a_be = 0;
    b_we = 0; b_wh = 0; b_re = 0; b_rh = 0; b_wa = 0; b_ra = 0; b_wd = 0; b_be = 0;
    repeat (3) @(negedge clk);
    // R12: outputs clear in reset
    check(a_rd == 16'h0, "R12", a_rd, 0);
    check(b_rd == 4'h0, "R12", b_rd, 0);
    rst_n = 1'b1;

    // R2, R4: fill both memories; B uses byte_en=0, which must not matter
    for (int i = 0; i < 1024; i++) begin
      a_we = (i < 256); a_wa = i[7:0]; a_be = 2'b11;
      a_wd = (i[15:0] * 16'h0101) ^ 16'h5a3c;
      b_we = 1'b1; b_wa = i[9:0]; b_be = 1'b0;
      b_wd = 4'((i * 7 + 3) % 16);
      @(negedge clk);
      if (i < 256) ma[i] = (i[15:0] * 16'h0101) ^ 16'h5a3c;
      mb[i] = 4'((i * 7 + 3) % 16);
    end
    a_we = 0; b_we = 0;

    // R10: one-edge latency sweep on A
    for (int i = 0; i < 256; i++) a_read(i, "R10");

    // R10, R8, R4: two-edge latency sweep on B, no read enable used
    for (int i = 0; i <= 1024; i++) begin
      b_ra = (i < 1024) ? i[9:0] : 10'd0;
      @(negedge clk);
      if (i >= 1) check(b_rd == mb[i-1], "R10", b_rd, mb[i-1]);
    end

    // R3: byte lane masking
    a_we = 1; a_be = 2'b01; a_wa = 8'd5; a_wd = 16'hFFFF; @(negedge clk);
    ma[5] = {ma[5][15:8], 8'hFF};
    a_be = 2'b10; a_wa = 8'd6; @(negedge clk);
    ma[6] = {8'hFF, ma[6][7:0]};
    a_be = 2'b00; a_wa = 8'd8; @(negedge clk);
    // R2: wr_en low leaves memory unchanged
    a_we = 0; a_be = 2'b11; a_wa = 8'd9; @(negedge clk);
    a_read(5, "R3"); a_read(6, "R3"); a_read(8, "R3"); a_read(9, "R2");

    // R9: same-address read and write
    a_we = 1; a_wa = 8'd7; a_wd = 16'h1234; a_re = 1; a_ra = 8'd7;
    @(negedge clk);
    check(a_rd == ma[7], "R9", a_rd, ma[7]);
    ma[7] = 16'h1234; a_we = 0;
    @(negedge clk);
    check(a_rd == 16'h1234, "R9", a_rd, 16'h1234);

    // R7: read enable low holds output
    a_read(9, "R7");
    a_re = 0; a_ra = 8'd10; @(negedge clk);
    check(a_rd == ma[9], "R7", a_rd, ma[9]);
    @(negedge clk);
    check(a_rd == ma[9], "R7", a_rd, ma[9]);

    // R5: read address hold
    a_read(11, "R5");
    a_rh = 1; a_ra = 8'd12; @(negedge clk);
    check(a_rd == ma[11], "R5", a_rd, ma[11]);
    a_rh = 0; @(negedge clk);
    check(a_rd == ma[12], "R5", a_rd, ma[12]);

    // R6: write address hold redirects to previous address
    a_re = 0; a_we = 1; a_wh = 0; a_wa = 8'd20; a_wd = 16'hAAAA; @(negedge clk);
    a_wh = 1; a_wa = 8'd21; a_wd = 16'h5555; @(negedge clk);
    a_we = 0; a_wh = 0;
    ma[20] = 16'h5555;
    a_read(20, "R6"); a_read(21, "R6");

    // R11: clock enable low freezes everything
    a_read(22, "R11");
    ce = 0; a_we = 1; a_wa = 8'd22; a_wd = 16'hDEAD; a_ra = 8'd23;
    @(negedge clk);
    check(a_rd == ma[22], "R11", a_rd, ma[22]);
    ce = 1; a_we = 0; a_ra = 8'd22; @(negedge clk);
    check(a_rd == ma[22], "R11", a_rd, ma[22]);

    // R8, R9, R10 on B: held read address tracks a write with no new request
    b_ra = 10'd40; @(negedge clk); @(negedge clk);
    check(b_rd == mb[40], "R8", b_rd, mb[40]);
    b_we = 1; b_wa = 10'd40; b_wd = ~mb[40]; @(negedge clk);
    check(b_rd == mb[40], "R9", b_rd, mb[40]);
    b_we = 0; @(negedge clk);
    check(b_rd == mb[40], "R10", b_rd, mb[40]);
    mb[40] = ~mb[40];
    @(negedge clk);
    check(b_rd == mb[40], "R8", b_rd, mb[40]);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule